// File: doc/BRIEF.md
# Re-encode bit error rate monitor

This block estimates the raw channel bit error rate seen at the input of a convolutional decoder without needing any known test pattern. Each decoded bit coming out of the decoder is fed back through a local copy of the transmit encoder. The re-encoded pair is punctured at the active code rate and compared with the received hard-decision pair that produced it. A delay line holds the received pairs long enough for the decoder's output to catch up. Every disagreement on a transmitted position counts as one channel error.

Errors are accumulated over a window whose length, in decoded data bits, is set by an 8-bit period value. When a window closes, the count is moved into a 24-bit result register and a fresh window begins. The result register keeps its value until the next window closes. Each new result raises a pending flag, and that flag drives the interrupt line when the interrupt enable is set.

The received side is presented one data-bit slot at a time: a pair of coded bits per `rx_valid`, with both positions present even when one was deleted by puncturing. The decoder is assumed to emit, on a `dec_valid` cycle, the data bit belonging to the slot that entered `DELAY` received strobes earlier.

Top module: `reenc_ber_mon`

## Requirements
- R1: After reset, `err_count` is 0 and `irq` is low.
- R2: The re-encoder is a constraint-length-7 encoder with generator taps 171 (first output) and 133 (second output) octal, starting from an all-zero state. At rate 1/2 (`rate_sel` = 0), every position where a re-encoded bit differs from the matching received bit adds one to the count.
- R3: `rate_sel` selects the puncturing: 1 = 2/3 (first output 10, second 11), 2 = 3/4 (101/110), 3 = 5/6 (10101/11010), 4 = 6/7 (100101/111010), 5 = 7/8 (1000101/1111010). In each pattern a 1 means the bit is sent and the leftmost bit is the first slot after reset or after a rate change. Values 6 and 7 act as rate 1/2. Mismatches on deleted positions are never counted.
- R4: A decoded bit presented with `dec_valid` is compared with the received pair that was accepted `DELAY` `rx_valid` strobes earlier. A clean stream aligned this way gives a count of 0.
- R5: A window spans `period`×256 decoded bits. The result loads on the clock edge that accepts the last bit of the window, including that bit's errors, and the next window starts from zero.
- R6: A `period` of 0 stops measurement: the result register is not loaded and no interrupt is raised.
- R7: `err_count` holds its value between window completions. Time passing and new errors do not change it until the next window closes.
- R8: Each result load sets a pending flag. `irq` is the pending flag gated by `irq_en`.
- R9: The pending flag stays set until `irq_ack` is high on a clock edge. A result that loads while the flag is pending replaces `err_count`, and the flag stays set.
- R10: Any change of `rate_sel` or `period` discards the partial count and restarts the window. The comparison made on the edge where the change is seen is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | A received coded pair is present |
| rx_x | input | 1 | Received hard decision, first encoder output |
| rx_y | input | 1 | Received hard decision, second encoder output |
| dec_valid | input | 1 | A decoded data bit is present |
| dec_bit | input | 1 | Decoded data bit |
| rate_sel | input | 3 | Code rate select (see R3) |
| period | input | 8 | Window length in units of 256 data bits; 0 stops measurement |
| irq_en | input | 1 | Interrupt enable |
| irq_ack | input | 1 | Clears the pending flag |
| err_count | output | 24 | Error count of the last completed window |
| irq | output | 1 | Interrupt request |

## Verification
The bench runs every code rate against a reference encoder and puncturer of its own. It also feeds a stream whose only corruptions sit on deleted positions; a puncturer with a wrong phase or a swapped pattern would count those errors. Window timing is probed one bit before and at the closing edge, so an off-by-one window length shows up as an early or late load. Other runs cover a result that is held through later errors, a second result arriving while the flag is still pending, an acknowledge, a period of zero, and a period change partway through a window. A design that kept the stale partial count or finished the window at the old length would load the wrong value or raise the interrupt 256 bits early.

// File: rtl/reenc_ber_pkg.sv
// Shared types and puncturing tables for the re-encode error monitor.
// Assumes code rates are coded 0..5 as 1/2, 2/3, 3/4, 5/6, 6/7, 7/8.
package reenc_ber_pkg;

    localparam int PAT_W = 8;

    // One received slot with its puncturing keep flags.
    typedef struct packed {
        logic cx;
        logic cy;
        logic kx;
        logic ky;
    } rx_sym_t;

    // Number of slots in one puncturing period.
    function automatic logic [2:0] punct_len(input logic [2:0] rate);
        case (rate)
            3'd1:    return 3'd2;
            3'd2:    return 3'd3;
            3'd3:    return 3'd5;
            3'd4:    return 3'd6;
            3'd5:    return 3'd7;
            default: return 3'd1;
        endcase
    endfunction

    // Keep flags {first, second} for a slot; bit i of each mask is slot i.
    function automatic logic [1:0] punct_keep(input logic [2:0] rate, input logic [2:0] ph);
        logic [PAT_W-1:0] px;
        logic [PAT_W-1:0] py;
        case (rate)
            3'd1:    begin px = 8'b0000_0001; py = 8'b0000_0011; end
            3'd2:    begin px = 8'b0000_0101; py = 8'b0000_0011; end
            3'd3:    begin px = 8'b0001_0101; py = 8'b0000_1011; end
            3'd4:    begin px = 8'b0010_1001; py = 8'b0001_0111; end
            3'd5:    begin px = 8'b0101_0001; py = 8'b0010_1111; end
            default: begin px = 8'b0000_0001; py = 8'b0000_0001; end
        endcase
        return {px[ph], py[ph]};
    endfunction

endpackage

// File: rtl/reenc_ber_delay.sv
// Latency-matching delay line for received pairs.
// Each accepted pair is tagged with its puncturing keep flags on entry,
// so the tag travels with the data and the compare side needs no phase.
// Assumes DEPTH >= 1; the puncture phase restarts when the rate changes.
module reenc_ber_delay
    import reenc_ber_pkg::*;
#(
    parameter int DEPTH = 136
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       in_x,
    input  logic       in_y,
    input  logic [2:0] rate,
    input  logic       rate_restart,
    output rx_sym_t    tap
);

    logic [2:0] phase;
    logic [2:0] ph_eff;
    logic [2:0] ph_nxt;
    logic [1:0] keep;
    rx_sym_t    stage [DEPTH];

    // Effective slot phase, its keep flags and the following phase.
    always_comb begin
        ph_eff = rate_restart ? 3'd0 : phase;
        keep   = punct_keep(rate, ph_eff);
        ph_nxt = ((ph_eff + 3'd1) >= punct_len(rate)) ? 3'd0 : ph_eff + 3'd1;
    end

    // Puncture phase counter, advanced once per received slot.
    always_ff @(posedge clk) begin
        if (!rst_n)            phase <= 3'd0;
        else if (in_valid)     phase <= ph_nxt;
        else if (rate_restart) phase <= 3'd0;
    end

    // Shift register of tagged slots, one step per received slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
        end else if (in_valid) begin
            stage[0] <= '{cx: in_x, cy: in_y, kx: keep[1], ky: keep[0]};
            for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
        end
    end

    assign tap = stage[DEPTH-1];

endmodule

// File: rtl/reenc_ber_cmp.sv
// Re-encodes decoded bits and compares them with the delayed received pair.
// Outputs the number of mismatching sent positions (0..2) for this bit.
// Assumes the encoder state starts at zero and advances only on dec_valid.
module reenc_ber_cmp
    import reenc_ber_pkg::*;
#(
    parameter int             K     = 7,
    parameter logic [K-1:0]   GEN_X = 'o171,
    parameter logic [K-1:0]   GEN_Y = 'o133
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dec_valid,
    input  logic       dec_bit,
    input  rx_sym_t    tap,
    output logic [1:0] err_n
);

    logic [K-2:0] hist;
    logic [K-1:0] win;
    logic         enc_x;
    logic         enc_y;
    logic         mis_x;
    logic         mis_y;

    // Encoder outputs for the current bit and mismatch count on kept positions.
    always_comb begin
        win   = {dec_bit, hist};
        enc_x = ^(win & GEN_X);
        enc_y = ^(win & GEN_Y);
        mis_x = tap.kx & (enc_x ^ tap.cx);
        mis_y = tap.ky & (enc_y ^ tap.cy);
        err_n = {1'b0, mis_x} + {1'b0, mis_y};
    end

    // Encoder history, newest bit in the top position.
    always_ff @(posedge clk) begin
        if (!rst_n)         hist <= '0;
        else if (dec_valid) hist <= {dec_bit, hist[K-2:1]};
    end

endmodule

// File: rtl/reenc_ber_win.sv
// Windowed error accumulator with a held result and a pending flag.
// The window is period << SCALE compared bits; period 0 stops counting.
// Assumes restart is high for one cycle whenever the configuration changes.
module reenc_ber_win #(
    parameter int PER_W = 8,
    parameter int SCALE = 8,
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_valid,
    input  logic [1:0]       err_n,
    input  logic             restart,
    input  logic [PER_W-1:0] period,
    input  logic             irq_ack,
    output logic [CNT_W-1:0] result,
    output logic [CNT_W-1:0] acc,
    output logic             done,
    output logic             pending
);

    localparam int LEN_W = PER_W + SCALE;

    logic [LEN_W-1:0] bit_cnt;
    logic [LEN_W-1:0] win_last;
    logic [CNT_W:0]   sum_w;
    logic [CNT_W-1:0] sum_sat;
    logic             active;

    // Window end index, saturating sum and end-of-window detect.
    always_comb begin
        win_last = {period, {SCALE{1'b0}}} - LEN_W'(1);
        active   = cmp_valid && !restart && (period != '0);
        sum_w    = {1'b0, acc} + (CNT_W+1)'(err_n);
        sum_sat  = sum_w[CNT_W] ? '1 : sum_w[CNT_W-1:0];
        done     = active && (bit_cnt == win_last);
    end

    // Accumulator and bit counter, cleared on restart and at window end.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || done) begin
            acc     <= '0;
            bit_cnt <= '0;
        end else if (active) begin
            acc     <= sum_sat;
            bit_cnt <= bit_cnt + LEN_W'(1);
        end
    end

    // Result register, loaded only when a window completes.
    always_ff @(posedge clk) begin
        if (!rst_n)    result <= '0;
        else if (done) result <= sum_sat;
    end

    // Pending flag: set by a new result, cleared by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)       pending <= 1'b0;
        else if (done)    pending <= 1'b1;
        else if (irq_ack) pending <= 1'b0;
    end

endmodule

// File: rtl/reenc_ber_mon.sv
// Top of the re-encode error monitor: delay line, re-encoder/comparator
// and windowed counter, plus configuration change detection.
// Assumes the decoder output lags the received slots by DELAY strobes.
module reenc_ber_mon
    import reenc_ber_pkg::*;
#(
    parameter int           DELAY = 136,
    parameter int           K     = 7,
    parameter logic [K-1:0] GEN_X = 'o171,
    parameter logic [K-1:0] GEN_Y = 'o133,
    parameter int           PER_W = 8,
    parameter int           SCALE = 8,
    parameter int           CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic             rx_x,
    input  logic             rx_y,
    input  logic             dec_valid,
    input  logic             dec_bit,
    input  logic [2:0]       rate_sel,
    input  logic [PER_W-1:0] period,
    input  logic             irq_en,
    input  logic             irq_ack,
    output logic [CNT_W-1:0] err_count,
    output logic             irq
);

    logic [2:0]       rate_q;
    logic [PER_W-1:0] period_q;
    logic             rate_chg;
    logic             cfg_chg;
    rx_sym_t          tap;
    logic [1:0]       err_n;
    logic [CNT_W-1:0] acc_val;
    logic             win_done;
    logic             irq_pend;

    // Previous configuration, captured every cycle including during reset.
    always_ff @(posedge clk) begin
        rate_q   <= rate_sel;
        period_q <= period;
    end

    // Configuration change detect.
    always_comb begin
        rate_chg = (rate_sel != rate_q);
        cfg_chg  = rate_chg || (period != period_q);
    end

    reenc_ber_delay #(.DEPTH(DELAY)) u_delay (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (rx_valid),
        .in_x         (rx_x),
        .in_y         (rx_y),
        .rate         (rate_sel),
        .rate_restart (rate_chg),
        .tap          (tap)
    );

    reenc_ber_cmp #(.K(K), .GEN_X(GEN_X), .GEN_Y(GEN_Y)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .dec_valid (dec_valid),
        .dec_bit   (dec_bit),
        .tap       (tap),
        .err_n     (err_n)
    );

    reenc_ber_win #(.PER_W(PER_W), .SCALE(SCALE), .CNT_W(CNT_W)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_valid (dec_valid),
        .err_n     (err_n),
        .restart   (cfg_chg),
        .period    (period),
        .irq_ack   (irq_ack),
        .result    (err_count),
        .acc       (acc_val),
        .done      (win_done),
        .pending   (irq_pend)
    );

    assign irq = irq_pend & irq_en;

endmodule

// File: rtl/reenc_ber_mon_chk.sv
// Assertion checker for reenc_ber_mon, attached with bind below.
module reenc_ber_mon_chk #(
    parameter int CNT_W = 24,
    parameter int PER_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             win_done,
    input logic             pending,
    input logic             irq_ack,
    input logic [CNT_W-1:0] result,
    input logic [CNT_W-1:0] acc,
    input logic             cfg_chg,
    input logic             dec_valid,
    input logic [1:0]       err_n,
    input logic             tap_kx,
    input logic             tap_ky,
    input logic [PER_W-1:0] period
);

    // R8
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |=> pending);

    // R9
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !irq_ack) |=> pending);

    // R9
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && irq_ack && !win_done) |=> !pending);

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_done |=> $stable(result));

    // R10
    restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_chg |=> (acc == '0));

    // R6
    idle_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (period == '0) |-> !win_done);

    // R3
    punct_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> (err_n <= ({1'b0, tap_kx} + {1'b0, tap_ky})));

endmodule

bind reenc_ber_mon reenc_ber_mon_chk #(.CNT_W(CNT_W), .PER_W(PER_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_done  (win_done),
    .pending   (irq_pend),
    .irq_ack   (irq_ack),
    .result    (err_count),
    .acc       (acc_val),
    .cfg_chg   (cfg_chg),
    .dec_valid (dec_valid),
    .err_n     (err_n),
    .tap_kx    (tap.kx),
    .tap_ky    (tap.ky),
    .period    (period)
);

// File: tb/sim_reenc_ber_mon.sv
// Directed bench for reenc_ber_mon with a reference encoder and window model.
module sim_reenc_ber_mon;

    localparam int CLK_PERIOD = 10;
    localparam int DLY        = 136;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic        rx_x = 1'b0;
    logic        rx_y = 1'b0;
    logic        dec_valid = 1'b0;
    logic        dec_bit = 1'b0;
    logic [2:0]  rate_sel = 3'd0;
    logic [7:0]  period = 8'd0;
    logic        irq_en = 1'b0;
    logic        irq_ack = 1'b0;
    logic [23:0] err_count;
    logic        irq;

    reenc_ber_mon #(.DELAY(DLY)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_x      (rx_x),
        .rx_y      (rx_y),
        .dec_valid (dec_valid),
        .dec_bit   (dec_bit),
        .rate_sel  (rate_sel),
        .period    (period),
        .irq_en    (irq_en),
        .irq_ack   (irq_ack),
        .err_count (err_count),
        .irq       (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int          n_tests = 0;
    int          n_fail  = 0;
    int          step;
    int          bph;
    logic [5:0]  h;
    logic [15:0] lfsr;
    logic        dbuf [256];
    int          ebuf [256];
    int          m_acc;
    int          m_cnt;
    int          m_res;
    bit          m_pend;
    bit          cfg_event;
    int          flip_mode;

    // Puncturing patterns written leftmost-slot first.
    function automatic void pat(input int r, output int len, output logic [6:0] xs, output logic [6:0] ys);
        case (r)
            1:       begin len = 2; xs = 7'b10;      ys = 7'b11;      end
            2:       begin len = 3; xs = 7'b101;     ys = 7'b110;     end
            3:       begin len = 5; xs = 7'b10101;   ys = 7'b11010;   end
            4:       begin len = 6; xs = 7'b100101;  ys = 7'b111010;  end
            5:       begin len = 7; xs = 7'b1000101; ys = 7'b1111010; end
            default: begin len = 1; xs = 7'b1;       ys = 7'b1;       end
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // One received slot (and decoded bit once the delay is filled).
    task automatic do_step();
        int len;
        logic [6:0] xs;
        logic [6:0] ys;
        logic d, ex, ey, kx, ky, fx, fy;
        int e;
        bit done;
        done = 0;
        pat(int'(rate_sel), len, xs, ys);
        d    = lfsr[0];
        lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
        ex   = d ^ h[0] ^ h[1] ^ h[2] ^ h[5];
        ey   = d ^ h[1] ^ h[2] ^ h[4] ^ h[5];
        h    = {h[4:0], d};
        kx   = xs[len-1-bph];
        ky   = ys[len-1-bph];
        bph  = (bph + 1) % len;
        case (flip_mode)
            1:       begin fx = (step % 7 == 3); fy = (step % 5 == 1); end
            2:       begin fx = !kx; fy = !ky; end
            default: begin fx = 1'b0; fy = 1'b0; end
        endcase
        e = int'(kx & fx) + int'(ky & fy);
        ebuf[step % 256] = e;
        dbuf[step % 256] = d;
        rx_valid = 1'b1;
        rx_x     = ex ^ fx;
        rx_y     = ey ^ fy;
        dec_valid = (step >= DLY);
        dec_bit   = (step >= DLY) ? dbuf[(step - DLY) % 256] : 1'b0;
        if (cfg_event) begin
            m_acc = 0;
            m_cnt = 0;
        end else if (step >= DLY && period != 0) begin
            m_acc += ebuf[(step - DLY) % 256];
            m_cnt++;
            if (m_cnt == int'(period) * 256) begin
                m_res  = m_acc;
                m_acc  = 0;
                m_cnt  = 0;
                m_pend = 1;
                done   = 1;
            end
        end
        if (irq_ack && !done) m_pend = 0;
        cfg_event = 0;
        step++;
        @(negedge clk);
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) do_step();
    endtask

    task automatic do_reset(input int r, input int p, input bit en);
        rst_n     = 1'b0;
        rx_valid  = 1'b0;
        dec_valid = 1'b0;
        irq_ack   = 1'b0;
        rate_sel  = 3'(r);
        period    = 8'(p);
        irq_en    = en;
        repeat (3) @(negedge clk);
        rst_n     = 1'b1;
        step = 0; bph = 0; h = '0; lfsr = 16'hACE1;
        m_acc = 0; m_cnt = 0; m_res = 0; m_pend = 0; cfg_event = 0;
    endtask

    task automatic set_cfg(input int r, input int p);
        if (3'(r) != rate_sel) bph = 0;
        rate_sel  = 3'(r);
        period    = 8'(p);
        cfg_event = 1;
    endtask

    task automatic t_reset();
        do_reset(0, 1, 1);
        chk("R1 count after reset", int'(err_count), 0);
        chk("R1 irq after reset", int'(irq), 0);
    endtask

    task automatic t_clean();
        do_reset(0, 1, 1);
        flip_mode = 0;
        steps(DLY + 255);
        chk("R5 no irq before window end", int'(irq), 0);
        do_step();
        chk("R4 clean aligned stream", int'(err_count), 0);
        chk("R8 irq on new result", int'(irq), 1);
    endtask

    task automatic t_rate(input int r);
        do_reset(r, 1, 1);
        flip_mode = 1;
        steps(DLY + 255);
        chk("R5 result not loaded early", int'(err_count), 0);
        chk("R5 irq not raised early", int'(irq), 0);
        do_step();
        chk((r == 0) ? "R2 rate 1/2 count" : "R3 punctured count", int'(err_count), m_res);
        chk("R8 irq after window", int'(irq), 1);
    endtask

    task automatic t_punct();
        do_reset(5, 1, 1);
        flip_mode = 2;
        steps(DLY + 256);
        chk("R3 deleted positions ignored", int'(err_count), 0);
        chk("R3 window still completes", int'(irq), 1);
    endtask

    task automatic t_hold();
        int first;
        do_reset(2, 1, 0);
        flip_mode = 1;
        steps(DLY + 256);
        first = m_res;
        chk("R8 irq gated off", int'(irq), 0);
        chk("R7 first result", int'(err_count), first);
        irq_en = 1'b1;
        #1;
        chk("R8 irq after enable", int'(irq), 1);
        steps(100);
        chk("R7 result held", int'(err_count), first);
        steps(156);
        chk("R9 overwrite while pending", int'(err_count), m_res);
        chk("R9 flag still set", int'(irq), 1);
        irq_ack = 1'b1;
        do_step();
        irq_ack = 1'b0;
        chk("R9 ack clears", int'(irq), 0);
        steps(10);
        chk("R9 stays clear", int'(irq), 0);
    endtask

    task automatic t_zero();
        do_reset(1, 0, 1);
        flip_mode = 1;
        steps(DLY + 600);
        chk("R6 no load at period 0", int'(err_count), 0);
        chk("R6 no irq at period 0", int'(irq), 0);
    endtask

    task automatic t_restart();
        do_reset(1, 1, 1);
        flip_mode = 1;
        steps(DLY + 150);
        set_cfg(1, 2);
        steps(300);
        chk("R10 old window discarded", int'(irq), 0);
        chk("R10 no stale load", int'(err_count), 0);
        steps(212);
        chk("R5 long window not done", int'(irq), 0);
        do_step();
        chk("R10 count after restart", int'(err_count), m_res);
        chk("R5 long window irq", int'(irq), 1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL all: watchdog got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_clean();
        for (int r = 0; r < 6; r++) t_rate(r);
        t_punct();
        t_hold();
        t_zero();
        t_restart();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule